// File: doc/BRIEF.md
# JTAG Character Port

The block carries a two-way byte stream between a debug host and on-chip software through JTAG data-register scans. It is one module on a debug chain. The TAP controller supplies the capture, shift and update strobes and the serial data, plus an enable that says this module is the one currently selected. Software on the chip sees two byte queues. It feeds characters for the host into a transmit queue and takes characters from the host out of a receive queue. Both queues use valid/ready handshakes.

Every scan is 72 bits long: a header byte, then eight payload slots. Data shifts in on TDI and out on TDO at the same time. At capture the device loads a status byte and up to eight queued characters. The upper nibble of the status byte counts the characters that follow, and the lower nibble counts the free receive slots. The host's header byte carries, in its upper nibble, how many of its payload bytes are meant to be written. One scan therefore writes and reads at once.

Nothing is committed until update, and only after a complete 72-bit shift. A scan that is abandoned or cut short leaves both queues untouched, and the same characters are reported again on the next scan.

Top module: `jtag_char_port`

## Requirements
- R1: After reset, tdo_o is 0, tx_ready_o is 1 and rx_valid_o is 0.
- R2: At capture the 72-bit register is loaded least significant bit first. TDO bits 0..7 are the status byte, and TDO bits 8k+8..8k+15 are payload slot k, for k from 0 to 7.
- R3: The status byte's upper nibble is min(transmit queue fill, 8) and its lower nibble is min(receive queue free space, 8). Both are taken at capture.
- R4: Device payload slot k holds the k-th oldest queued transmit character when k is below the reported count, and 0 otherwise.
- R5: The host header's upper nibble (TDI bits 4..7) is the write count, clamped to 8. At update, min(write count, captured free space) host slots are appended to the receive queue in slot order, and the rest are dropped.
- R6: The reported transmit characters leave the queue only at update of a complete scan. A scan without update leaves them queued.
- R7: Shift cycles after the 72nd bit have no effect on the frame, whatever their TDI value.
- R8: An update after fewer than 72 shift cycles neither writes nor removes any character.
- R9: While sel_i is low, the capture, shift and update strobes are ignored.
- R10: Each queue holds DEPTH characters (default 16, at least 8, a power of two). tx_ready_o is low when the transmit queue is full, and both queues deliver bytes in arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared with the TAP strobes |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 1 | This module is the selected chain module |
| capture_i | input | 1 | Capture-DR strobe |
| shift_i | input | 1 | Shift-DR strobe, one bit per cycle |
| update_i | input | 1 | Update-DR strobe |
| tdi_i | input | 1 | Serial data from the host |
| tdo_o | output | 1 | Serial data to the host |
| tx_data_i | input | 8 | Character from software for the host |
| tx_valid_i | input | 1 | tx_data_i is valid |
| tx_ready_o | output | 1 | Transmit queue has room |
| rx_data_o | output | 8 | Oldest character received from the host |
| rx_valid_o | output | 1 | Receive queue is not empty |
| rx_ready_i | input | 1 | Software takes rx_data_o |

## Verification
The assertions assume that the TAP strobes are mutually exclusive and arrive in order: capture first, then shifts, then update. They also assume that only the update of a scan changes the queues in the TAP's favour, so no queue can be refilled or drained on the wrong side between two edges. The bench keeps within these assumptions. It raises one strobe per cycle, keeps sel_i steady for the whole scan, and drives software traffic only between scans. Under these conditions, the captured free space and the captured fill are safe limits at update.

// File: rtl/jcp_pkg.sv
`timescale 1ns/1ps
package jcp_pkg;
  localparam int FRAME_BITS = 72;
  localparam int SLOTS      = 8;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int NIB_W      = 4;

  typedef logic [SLOTS-1:0][7:0] payload_t;
  typedef logic [NIB_W-1:0]      nib_t;

  function automatic nib_t clamp_nib(input int unsigned v);
    return (v > SLOTS) ? nib_t'(SLOTS) : nib_t'(v);
  endfunction
endpackage

// File: rtl/jcp_fifo.sv
`timescale 1ns/1ps
module jcp_fifo
  import jcp_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  nib_t          push_n_i,
  input  payload_t      push_data_i,
  input  nib_t          pop_n_i,
  output payload_t      peek_o,
  output logic [CW-1:0] count_o
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count_q;

  // multi-slot write: caller guarantees push_n_i <= free space
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      for (int k = 0; k < SLOTS; k++) begin
        if (k < int'(push_n_i)) mem[wr_ptr + AW'(k)] <= push_data_i[k];
      end
      wr_ptr  <= wr_ptr + AW'(push_n_i);
      rd_ptr  <= rd_ptr + AW'(pop_n_i);
      count_q <= count_q + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_peek
    assign peek_o[k] = mem[rd_ptr + AW'(k)];
  end

  assign count_o = count_q;
endmodule

// File: rtl/jcp_frame.sv
`timescale 1ns/1ps
module jcp_frame
  import jcp_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     cap_i,
  input  logic     sft_i,
  input  logic     upd_i,
  input  logic     tdi_i,
  input  nib_t     avail_i,
  input  nib_t     free_i,
  input  payload_t tx_bytes_i,
  output logic     tdo_o,
  output logic     commit_o,
  output nib_t     pop_n_o,
  output nib_t     push_n_o,
  output payload_t rx_bytes_o
);
  logic [FRAME_BITS-1:0] sr_q;
  logic [CNT_W-1:0]      bit_cnt_q;
  logic                  armed_q;
  nib_t                  cap_avail_q, cap_free_q;
  logic                  full_frame;
  nib_t                  wr_req;

  assign full_frame = (bit_cnt_q == CNT_W'(FRAME_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q        <= '0;
      bit_cnt_q   <= '0;
      armed_q     <= 1'b0;
      cap_avail_q <= '0;
      cap_free_q  <= '0;
    end else if (cap_i) begin
      sr_q        <= {tx_bytes_i, avail_i, free_i};
      bit_cnt_q   <= '0;
      armed_q     <= 1'b1;
      cap_avail_q <= avail_i;
      cap_free_q  <= free_i;
    end else if (sft_i) begin
      // freeze once the frame is complete: trailing pad bits are dropped
      if (!full_frame) begin
        sr_q      <= {tdi_i, sr_q[FRAME_BITS-1:1]};
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end
    end else if (upd_i) begin
      armed_q <= 1'b0;
    end
  end

  assign wr_req     = clamp_nib(int'(sr_q[7:4]));
  assign tdo_o      = full_frame ? 1'b0 : sr_q[0];
  assign commit_o   = upd_i & armed_q & full_frame;
  assign pop_n_o    = cap_avail_q;
  assign push_n_o   = (wr_req < cap_free_q) ? wr_req : cap_free_q;
  assign rx_bytes_o = payload_t'(sr_q[FRAME_BITS-1:8]);
endmodule

// File: rtl/jtag_char_port.sv
`timescale 1ns/1ps
module jtag_char_port
  import jcp_pkg::*;
#(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic       capture_i,
  input  logic       shift_i,
  input  logic       update_i,
  input  logic       tdi_i,
  output logic       tdo_o,
  input  logic [7:0] tx_data_i,
  input  logic       tx_valid_i,
  output logic       tx_ready_o,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  input  logic       rx_ready_i
);
  logic [CW-1:0] tx_cnt, rx_cnt;
  payload_t      tx_peek, tx_shown, rx_peek, host_bytes;
  nib_t          avail, free_sp, pop_n, push_n;
  nib_t          tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
  logic          commit;

  assign avail   = clamp_nib(int'(tx_cnt));
  assign free_sp = clamp_nib(DEPTH - int'(rx_cnt));

  for (genvar k = 0; k < SLOTS; k++) begin : g_mask
    assign tx_shown[k] = (nib_t'(k) < avail) ? tx_peek[k] : 8'h00;
  end

  jcp_frame i_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (sel_i & capture_i),
    .sft_i      (sel_i & shift_i),
    .upd_i      (sel_i & update_i),
    .tdi_i      (tdi_i),
    .avail_i    (avail),
    .free_i     (free_sp),
    .tx_bytes_i (tx_shown),
    .tdo_o      (tdo_o),
    .commit_o   (commit),
    .pop_n_o    (pop_n),
    .push_n_o   (push_n),
    .rx_bytes_o (host_bytes)
  );

  assign tx_ready_o = (tx_cnt != CW'(DEPTH));
  assign tx_push_n  = {3'b000, tx_valid_i & tx_ready_o};
  assign tx_pop_n   = commit ? pop_n : '0;

  jcp_fifo #(.DEPTH(DEPTH)) i_tx_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_n_i    (tx_push_n),
    .push_data_i ({{(SLOTS-1){8'h00}}, tx_data_i}),
    .pop_n_i     (tx_pop_n),
    .peek_o      (tx_peek),
    .count_o     (tx_cnt)
  );

  assign rx_valid_o = (rx_cnt != '0);
  assign rx_data_o  = rx_peek[0];
  assign rx_push_n  = commit ? push_n : '0;
  assign rx_pop_n   = {3'b000, rx_valid_o & rx_ready_i};

  jcp_fifo #(.DEPTH(DEPTH)) i_rx_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_n_i    (rx_push_n),
    .push_data_i (host_bytes),
    .pop_n_i     (rx_pop_n),
    .peek_o      (rx_peek),
    .count_o     (rx_cnt)
  );
endmodule

// File: rtl/jcp_checker.sv
`timescale 1ns/1ps
module jcp_checker #(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sel_i,
  input logic          capture_i,
  input logic          shift_i,
  input logic          update_i,
  input logic          tdo_o,
  input logic [CW-1:0] tx_cnt_i,
  input logic [CW-1:0] rx_cnt_i
);
  assert_rx_grows_on_update_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sel_i && update_i) |-> rx_cnt_i <= $past(rx_cnt_i));

  assert_rx_push_bounded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(rx_cnt_i) <= int'($past(rx_cnt_i)) + 8);

  assert_tx_drains_on_update_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sel_i && update_i) |-> tx_cnt_i >= $past(tx_cnt_i));

  assert_tdo_idle_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sel_i && (capture_i || shift_i)) |-> $stable(tdo_o));

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(tx_cnt_i) <= DEPTH) && (int'(rx_cnt_i) <= DEPTH));
endmodule

bind jtag_char_port jcp_checker #(.DEPTH(DEPTH)) i_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sel_i     (sel_i),
  .capture_i (capture_i),
  .shift_i   (shift_i),
  .update_i  (update_i),
  .tdo_o     (tdo_o),
  .tx_cnt_i  (tx_cnt),
  .rx_cnt_i  (rx_cnt)
);

// File: tb/test_jtag_char_port.sv
`timescale 1ns/1ps
module test_jtag_char_port;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic sel = 1'b0, cap = 1'b0, sft = 1'b0, upd = 1'b0, tdi = 1'b0, tdo;
  logic [7:0] tx_data = '0, rx_data;
  logic tx_valid = 1'b0, tx_ready, rx_valid, rx_ready = 1'b0;

  jtag_char_port #(.DEPTH(DEPTH)) i_jtag_char_port (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .capture_i(cap), .shift_i(sft),
    .update_i(upd), .tdi_i(tdi), .tdo_o(tdo), .tx_data_i(tx_data),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready), .rx_data_o(rx_data),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready)
  );

  int checks = 0, errors = 0;
  logic [7:0] txq[$], rxq[$];
  logic [7:0] tx_seed = 8'h11, host_seed = 8'h40;

  function automatic int mn(int a, int b);
    return (a < b) ? a : b;
  endfunction

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic push_tx(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_data  = tx_seed;
      tx_valid = 1'b1;
      if (tx_ready) txq.push_back(tx_seed);
      tx_seed += 8'd13;
      @(posedge clk);
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic raw_scan(input int hdr, input int nbits, input bit pad, input bit do_upd,
                          input bit en, output logic [71:0] got);
    logic [71:0] vec;
    vec[7:0] = {4'(hdr), 4'h0};
    for (int k = 0; k < 8; k++) vec[8*k+8 +: 8] = host_seed + 8'(3*k);
    got = '0;
    @(negedge clk);
    sel = en;
    cap = 1'b1;
    @(posedge clk);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      cap = 1'b0;
      sft = 1'b1;
      tdi = (i < 72) ? vec[i] : pad;
      if (i < 72) got[i] = tdo;
      @(posedge clk);
    end
    @(negedge clk);
    cap = 1'b0;
    sft = 1'b0;
    upd = do_upd;
    @(posedge clk);
    @(negedge clk);
    upd = 1'b0;
    sel = 1'b0;
  endtask

  // complete scan with model prediction; nbits may exceed 72 (pad bits)
  task automatic full_scan(string rq, int hdr, int nbits = 72, bit pad = 1'b0);
    logic [71:0] got;
    int avail, free_sp, acc;
    avail   = mn(txq.size(), 8);
    free_sp = mn(DEPTH - rxq.size(), 8);
    raw_scan(hdr, nbits, pad, 1'b1, 1'b1, got);
    chk(got[7:4] == 4'(avail), {rq, " R3"}, "status avail", int'(got[7:4]), avail);
    chk(got[3:0] == 4'(free_sp), {rq, " R3"}, "status free", int'(got[3:0]), free_sp);
    for (int k = 0; k < 8; k++) begin
      logic [7:0] e;
      e = (k < avail) ? txq[k] : 8'h00;
      chk(got[8*k+8 +: 8] == e, {rq, " R2 R4"}, $sformatf("slot %0d", k),
          int'(got[8*k+8 +: 8]), int'(e));
    end
    for (int k = 0; k < avail; k++) void'(txq.pop_front());
    acc = mn(mn(hdr, 8), free_sp);
    for (int k = 0; k < acc; k++) rxq.push_back(host_seed + 8'(3*k));
    host_seed += 8'h21;
  endtask

  task automatic drain_rx(string rq);
    while (rxq.size() > 0) begin
      @(negedge clk);
      rx_ready = 1'b1;
      chk(rx_valid == 1'b1, rq, "rx_valid", int'(rx_valid), 1);
      chk(rx_data == rxq[0], rq, "rx_data", int'(rx_data), int'(rxq[0]));
      void'(rxq.pop_front());
      @(posedge clk);
    end
    @(negedge clk);
    rx_ready = 1'b0;
    chk(rx_valid == 1'b0, rq, "rx empty", int'(rx_valid), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    logic [71:0] got;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(tdo == 1'b0, "R1", "tdo", int'(tdo), 0);
    chk(tx_ready == 1'b1, "R1", "tx_ready", int'(tx_ready), 1);
    chk(rx_valid == 1'b0, "R1", "rx_valid", int'(rx_valid), 0);

    // R3/R4/R6: sweep transmit fill 0..12, drain through scans
    for (int n = 0; n <= 12; n++) begin
      push_tx(n);
      full_scan("R6", 0);
      while (txq.size() > 0) full_scan("R6", 0);
    end

    // R5: sweep host write nibble 0..15 (above 8 clamps)
    for (int h = 0; h < 16; h++) begin
      full_scan("R5", h);
      drain_rx("R5");
    end

    // R5: free space limits acceptance (8, 5, then 3 of 8, then 0)
    full_scan("R5", 8);
    full_scan("R5", 5);
    full_scan("R5", 8);
    full_scan("R5", 8);
    drain_rx("R5");

    // R6: scan without update keeps characters queued
    push_tx(3);
    raw_scan(8, 72, 1'b0, 1'b0, 1'b1, got);
    chk(got[7:4] == 4'd3, "R6", "abort avail", int'(got[7:4]), 3);
    chk(got[15:8] == txq[0], "R6", "abort slot0", int'(got[15:8]), int'(txq[0]));
    chk(rx_valid == 1'b0, "R6", "abort rx", int'(rx_valid), 0);
    full_scan("R6", 0);

    // R8: short scan followed by update changes nothing
    push_tx(2);
    raw_scan(8, 40, 1'b0, 1'b1, 1'b1, got);
    chk(rx_valid == 1'b0, "R8", "short rx", int'(rx_valid), 0);
    full_scan("R8", 0);
    drain_rx("R8");

    // R7: pad bit of value 1 past bit 72 is ignored
    push_tx(4);
    full_scan("R7", 6, 73, 1'b1);
    drain_rx("R7");
    full_scan("R7", 0);

    // R9: strobes with sel low are ignored
    push_tx(2);
    raw_scan(5, 72, 1'b0, 1'b1, 1'b0, got);
    chk(got == '0, "R9", "tdo while deselected", int'(got[31:0]), 0);
    chk(rx_valid == 1'b0, "R9", "rx", int'(rx_valid), 0);
    full_scan("R9", 0);
    drain_rx("R9");

    // R10: transmit queue full, extra pushes refused, order kept
    push_tx(DEPTH + 3);
    @(negedge clk);
    chk(tx_ready == 1'b0, "R10", "tx_ready full", int'(tx_ready), 0);
    chk(txq.size() == DEPTH, "R10", "accepted", txq.size(), DEPTH);
    full_scan("R10", 0);
    full_scan("R10", 0);
    @(negedge clk);
    chk(tx_ready == 1'b1, "R10", "tx_ready after", int'(tx_ready), 1);
    full_scan("R10", 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule